// File: doc/BRIEF.md
# RV32I Single-Cycle Control Decoder

This block is the control unit of a one-instruction-per-cycle RV32I datapath. It looks only at the fetched 32-bit instruction word and at the two flags from the branch comparator, which report whether the operands are equal and whether the first is less than the second. It produces every select and enable the datapath needs in that cycle. Those are the immediate format, the register-file write enable, signed or unsigned comparison, the sources of both ALU operands, the ALU operation, the data-memory write enable, the writeback source and the next-PC source.

The block is purely combinational, so its outputs follow the instruction word within the same cycle. The datapath elements it steers (ALU, register file, immediate generator, memories) sit outside it. For any class of instruction, each output that the class does not use is still driven to a fixed default. An instruction word whose opcode the block does not recognise cannot change architectural state.

Top module: `rv32i_ctrl_decoder`

## Requirements
- R1: For register-register arithmetic (opcode 0110011), the ALU operation comes from funct3 (instr[14:12]) and instr[30]. The codes are add=0, sub=1, sll=2, slt=3, sltu=4, xor=5, srl=6, sra=7, or=8, and=9. funct3=000 gives sub when instr[30]=1 and add otherwise, and funct3=101 gives sra when instr[30]=1 and srl otherwise. Operand A is the register (opa_pc=0), operand B is the register (opb_imm=0), rf_wen=1 and wb_src=1 (ALU).
- R2: For immediate arithmetic (opcode 0010011), imm_fmt=0 (I-format) and opb_imm=1, with rf_wen=1 and wb_src=1. The ALU operation follows the R1 table, except that funct3=000 always gives add. Only funct3=101 uses instr[30], to choose sra.
- R3: Loads (opcode 0000011) give imm_fmt=0, opb_imm=1, alu_op=add, dmem_wen=0, rf_wen=1 and wb_src=0 (memory data).
- R4: Stores (opcode 0100011) give imm_fmt=1 (S-format), opb_imm=1, alu_op=add, dmem_wen=1, rf_wen=0 and wb_src=1 (fixed default).
- R5: Conditional branches (opcode 1100011) give imm_fmt=2 (B-format), opa_pc=1, opb_imm=1, alu_op=add, rf_wen=0 and dmem_wen=0.
- R6: The branch outcome drives pc_redirect (1 = ALU result, 0 = PC+4), decoded from funct3. The codes are 000 equal (cmp_eq=1), 001 not equal (cmp_eq=0), 100 and 110 less-than (cmp_lt=1), and 101 and 111 greater-or-equal (cmp_lt=0). funct3 values 010 and 011 are never taken.
- R7: cmp_unsigned=1 only for a branch with funct3 110 or 111. It is 0 for every other instruction.
- R8: jalr (opcode 1100111) gives imm_fmt=0, opa_pc=0, opb_imm=1, alu_op=add, rf_wen=1, wb_src=2 (PC+4) and pc_redirect=1.
- R9: jal (opcode 1101111) gives imm_fmt=3 (J-format), opa_pc=1, opb_imm=1, alu_op=add, rf_wen=1, wb_src=2 and pc_redirect=1.
- R10: Any other opcode gives rf_wen=0, dmem_wen=0 and pc_redirect=0. The remaining outputs take their defaults: imm_fmt=0, opa_pc=0, opb_imm=0, alu_op=add, wb_src=1, cmp_unsigned=0. The all-zero instruction word is one such opcode.
- R11: For any class other than branch, jal and jalr, pc_redirect stays 0 whatever the comparator flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction being executed this cycle |
| cmp_eq | input | 1 | Comparator: operands equal |
| cmp_lt | input | 1 | Comparator: operand A less than operand B |
| imm_fmt | output | 2 | Immediate format: 0 I, 1 S, 2 B, 3 J |
| rf_wen | output | 1 | Register-file write enable |
| cmp_unsigned | output | 1 | Comparator uses unsigned less-than |
| opa_pc | output | 1 | ALU operand A: 0 register, 1 PC |
| opb_imm | output | 1 | ALU operand B: 0 register, 1 immediate |
| alu_op | output | 4 | ALU operation code |
| dmem_wen | output | 1 | Data memory: 1 write, 0 read |
| wb_src | output | 2 | Writeback: 0 memory, 1 ALU, 2 PC+4 |
| pc_redirect | output | 1 | Next PC: 0 PC+4, 1 ALU result |

## Verification
The bench builds the block with its default parameters: a 32-bit instruction word and a 4-bit ALU operation code. At those values the full space that matters can be reached by stimulus. That space is every funct3 value and both settings of instr[30] within each of the seven recognised opcodes, together with all four combinations of the comparator flags. Random opcodes and the rest of the instruction bits cover the unrecognised-opcode path and show that fields the decoder ignores have no effect. Directed words pin down each branch condition on both outcomes, the two reserved branch codes and the alternate-encoding cases of subtract and arithmetic shift.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int OPC_W    = 7;
  localparam int OPC_LSB  = 0;
  localparam int F3_W     = 3;
  localparam int F3_LSB   = 12;
  localparam int ALT_BIT  = 30;
  localparam int ALU_OP_W = 4;

  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

  typedef enum logic [1:0] {
    IMM_I = 2'd0,
    IMM_S = 2'd1,
    IMM_B = 2'd2,
    IMM_J = 2'd3
  } imm_fmt_e;

  typedef enum logic [ALU_OP_W-1:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_SLL  = 4'd2,
    ALU_SLT  = 4'd3,
    ALU_SLTU = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_SRL  = 4'd6,
    ALU_SRA  = 4'd7,
    ALU_OR   = 4'd8,
    ALU_AND  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_MEM = 2'd0,
    WB_ALU = 2'd1,
    WB_PC4 = 2'd2
  } wb_src_e;

  typedef enum logic [2:0] {
    CL_ILLEGAL = 3'd0,
    CL_OP      = 3'd1,
    CL_OPIMM   = 3'd2,
    CL_LOAD    = 3'd3,
    CL_STORE   = 3'd4,
    CL_BRANCH  = 3'd5,
    CL_JALR    = 3'd6,
    CL_JAL     = 3'd7
  } insn_class_e;

  typedef struct packed {
    imm_fmt_e imm_fmt;
    logic     rf_wen;
    logic     opa_pc;
    logic     opb_imm;
    logic     dmem_wen;
    wb_src_e  wb_src;
    logic     is_jump;
  } class_ctrl_t;

endpackage

// File: rtl/rvdec_class_decode.sv
module rvdec_class_decode
  import rvdec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output insn_class_e      insn_class
);

  always_comb begin
    unique case (opcode)
      OPC_OP:     insn_class = CL_OP;
      OPC_OPIMM:  insn_class = CL_OPIMM;
      OPC_LOAD:   insn_class = CL_LOAD;
      OPC_STORE:  insn_class = CL_STORE;
      OPC_BRANCH: insn_class = CL_BRANCH;
      OPC_JALR:   insn_class = CL_JALR;
      OPC_JAL:    insn_class = CL_JAL;
      default:    insn_class = CL_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/rvdec_alu_ctrl.sv
module rvdec_alu_ctrl
  import rvdec_pkg::*;
(
  input  insn_class_e     insn_class,
  input  logic [F3_W-1:0] funct3,
  input  logic            alt_bit,
  output alu_op_e         alu_op
);

  logic    arith_class;
  logic    allow_sub;
  alu_op_e f3_op;

  // Only register-register arithmetic may turn add into subtract.
  assign arith_class = (insn_class == CL_OP) || (insn_class == CL_OPIMM);
  assign allow_sub   = (insn_class == CL_OP);

  always_comb begin
    unique case (funct3)
      3'b000:  f3_op = (allow_sub && alt_bit) ? ALU_SUB : ALU_ADD;
      3'b001:  f3_op = ALU_SLL;
      3'b010:  f3_op = ALU_SLT;
      3'b011:  f3_op = ALU_SLTU;
      3'b100:  f3_op = ALU_XOR;
      3'b101:  f3_op = alt_bit ? ALU_SRA : ALU_SRL;
      3'b110:  f3_op = ALU_OR;
      default: f3_op = ALU_AND;
    endcase
  end

  assign alu_op = arith_class ? f3_op : ALU_ADD;

endmodule

// File: rtl/rvdec_branch_eval.sv
module rvdec_branch_eval
  import rvdec_pkg::*;
(
  input  logic            is_branch,
  input  logic [F3_W-1:0] funct3,
  input  logic            cmp_eq,
  input  logic            cmp_lt,
  output logic            cmp_unsigned,
  output logic            taken
);

  logic use_lt;
  logic invert;
  logic legal;
  logic raw_flag;

  // funct3[2] picks the less-than flag, funct3[1] the unsigned variant,
  // funct3[0] the inverted sense; 010 and 011 are reserved.
  assign use_lt   = funct3[2];
  assign invert   = funct3[0];
  assign legal    = funct3[2] || !funct3[1];
  assign raw_flag = use_lt ? cmp_lt : cmp_eq;

  assign cmp_unsigned = is_branch && funct3[2] && funct3[1];
  assign taken        = is_branch && legal && (raw_flag ^ invert);

endmodule

// File: rtl/rv32i_ctrl_decoder.sv
module rv32i_ctrl_decoder
  import rvdec_pkg::*;
#(
  parameter int ILEN   = 32,
  parameter int AOP_W  = ALU_OP_W
) (
  input  logic [ILEN-1:0]  instr_word,
  input  logic             cmp_eq,
  input  logic             cmp_lt,
  output logic [1:0]       imm_fmt,
  output logic             rf_wen,
  output logic             cmp_unsigned,
  output logic             opa_pc,
  output logic             opb_imm,
  output logic [AOP_W-1:0] alu_op,
  output logic             dmem_wen,
  output logic [1:0]       wb_src,
  output logic             pc_redirect
);

  localparam int RD_LSB = OPC_LSB + OPC_W;

  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  funct3;
  logic             alt_bit;
  insn_class_e      insn_class;
  alu_op_e          alu_op_int;
  class_ctrl_t      ctl;
  logic             br_taken;
  logic             unused_fields;

  assign opcode  = instr_word[OPC_LSB +: OPC_W];
  assign funct3  = instr_word[F3_LSB +: F3_W];
  assign alt_bit = instr_word[ALT_BIT];

  // Register specifiers and upper immediate bits steer the datapath only.
  assign unused_fields = ^{instr_word[ILEN-1], instr_word[ALT_BIT-1:F3_LSB+F3_W],
                           instr_word[F3_LSB-1:RD_LSB]};

  rvdec_class_decode u_class (
    .opcode     (opcode),
    .insn_class (insn_class)
  );

  rvdec_alu_ctrl u_alu (
    .insn_class (insn_class),
    .funct3     (funct3),
    .alt_bit    (alt_bit),
    .alu_op     (alu_op_int)
  );

  rvdec_branch_eval u_branch (
    .is_branch    (insn_class == CL_BRANCH),
    .funct3       (funct3),
    .cmp_eq       (cmp_eq),
    .cmp_lt       (cmp_lt),
    .cmp_unsigned (cmp_unsigned),
    .taken        (br_taken)
  );

  always_comb begin
    ctl = '{imm_fmt: IMM_I, rf_wen: 1'b0, opa_pc: 1'b0, opb_imm: 1'b0,
            dmem_wen: 1'b0, wb_src: WB_ALU, is_jump: 1'b0};
    unique case (insn_class)
      CL_OP: begin
        ctl.rf_wen = 1'b1;
      end
      CL_OPIMM: begin
        ctl.rf_wen  = 1'b1;
        ctl.opb_imm = 1'b1;
      end
      CL_LOAD: begin
        ctl.rf_wen  = 1'b1;
        ctl.opb_imm = 1'b1;
        ctl.wb_src  = WB_MEM;
      end
      CL_STORE: begin
        ctl.imm_fmt  = IMM_S;
        ctl.opb_imm  = 1'b1;
        ctl.dmem_wen = 1'b1;
      end
      CL_BRANCH: begin
        ctl.imm_fmt = IMM_B;
        ctl.opa_pc  = 1'b1;
        ctl.opb_imm = 1'b1;
      end
      CL_JALR: begin
        ctl.rf_wen  = 1'b1;
        ctl.opb_imm = 1'b1;
        ctl.wb_src  = WB_PC4;
        ctl.is_jump = 1'b1;
      end
      CL_JAL: begin
        ctl.imm_fmt = IMM_J;
        ctl.rf_wen  = 1'b1;
        ctl.opa_pc  = 1'b1;
        ctl.opb_imm = 1'b1;
        ctl.wb_src  = WB_PC4;
        ctl.is_jump = 1'b1;
      end
      default: ;
    endcase
  end

  assign imm_fmt     = ctl.imm_fmt;
  assign rf_wen      = ctl.rf_wen;
  assign opa_pc      = ctl.opa_pc;
  assign opb_imm     = ctl.opb_imm;
  assign dmem_wen    = ctl.dmem_wen;
  assign wb_src      = ctl.wb_src;
  assign alu_op      = AOP_W'(alu_op_int);
  assign pc_redirect = ctl.is_jump || br_taken;

endmodule

// File: rtl/rvdec_checker.sv
module rvdec_checker
  import rvdec_pkg::*;
(
  input logic [31:0] instr_word,
  input logic        cmp_eq,
  input logic        cmp_lt,
  input logic [1:0]  imm_fmt,
  input logic        rf_wen,
  input logic        cmp_unsigned,
  input logic        opa_pc,
  input logic        opb_imm,
  input logic [3:0]  alu_op,
  input logic        dmem_wen,
  input logic [1:0]  wb_src,
  input logic        pc_redirect
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic       known;
  logic       ctrl_flow;

  assign opc       = instr_word[6:0];
  assign f3        = instr_word[14:12];
  assign known     = (opc == OPC_OP) || (opc == OPC_OPIMM) || (opc == OPC_LOAD) ||
                     (opc == OPC_STORE) || (opc == OPC_BRANCH) || (opc == OPC_JALR) ||
                     (opc == OPC_JAL);
  assign ctrl_flow = (opc == OPC_BRANCH) || (opc == OPC_JALR) || (opc == OPC_JAL);

  always_comb begin
    if (!$isunknown({instr_word, cmp_eq, cmp_lt})) begin
      if (opc == OPC_OP)
        assert_regreg_ctrl_R1: assert (!opb_imm && !opa_pc && rf_wen && wb_src == 2'd1);
      if (opc == OPC_OPIMM)
        assert_immarith_nosub_R2: assert (opb_imm && rf_wen && alu_op != 4'd1 && imm_fmt == 2'd0);
      if (opc == OPC_LOAD)
        assert_load_wb_mem_R3: assert (rf_wen && !dmem_wen && wb_src == 2'd0 && alu_op == 4'd0);
      if (dmem_wen)
        assert_store_no_rfwrite_R4: assert (!rf_wen && imm_fmt == 2'd1);
      if (opc == OPC_BRANCH)
        assert_branch_ctrl_R5: assert (!rf_wen && opa_pc && opb_imm && imm_fmt == 2'd2);
      if (opc == OPC_BRANCH && f3 == 3'b000)
        assert_beq_follows_eq_R6: assert (pc_redirect == cmp_eq);
      if (cmp_unsigned)
        assert_unsigned_only_branch_R7: assert (opc == OPC_BRANCH && f3[2:1] == 2'b11);
      if (opc == OPC_JALR)
        assert_jalr_ctrl_R8: assert (!opa_pc && pc_redirect && wb_src == 2'd2 && rf_wen);
      if (opc == OPC_JAL)
        assert_jal_ctrl_R9: assert (opa_pc && pc_redirect && wb_src == 2'd2 && imm_fmt == 2'd3);
      if (!known)
        assert_unknown_safe_R10: assert (!rf_wen && !dmem_wen && !pc_redirect);
      if (pc_redirect)
        assert_redirect_ctrlflow_R11: assert (ctrl_flow);
    end
  end

endmodule

bind rv32i_ctrl_decoder rvdec_checker u_rvdec_checker (.*);

// File: tb/tb_rv32i_ctrl_decoder.sv
module tb_rv32i_ctrl_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic [31:0] instr_word;
  logic        cmp_eq, cmp_lt;
  logic [1:0]  imm_fmt;
  logic        rf_wen, cmp_unsigned, opa_pc, opb_imm;
  logic [3:0]  alu_op;
  logic        dmem_wen;
  logic [1:0]  wb_src;
  logic        pc_redirect;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  rv32i_ctrl_decoder dut (
    .instr_word(instr_word), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt),
    .imm_fmt(imm_fmt), .rf_wen(rf_wen), .cmp_unsigned(cmp_unsigned),
    .opa_pc(opa_pc), .opb_imm(opb_imm), .alu_op(alu_op),
    .dmem_wen(dmem_wen), .wb_src(wb_src), .pc_redirect(pc_redirect)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Bundle: {imm_fmt, rf_wen, cmp_unsigned, opa_pc, opb_imm, alu_op, dmem_wen, wb_src, pc_redirect}
  function automatic logic [13:0] pack_out(logic [1:0] im, logic rw, logic un, logic pa,
                                           logic pb, logic [3:0] op, logic mw,
                                           logic [1:0] wb, logic pr);
    return {im, rw, un, pa, pb, op, mw, wb, pr};
  endfunction

  function automatic logic [3:0] arith_op(logic [2:0] f3, logic alt, logic reg_form);
    case (f3)
      3'd0: return (reg_form && alt) ? 4'd1 : 4'd0;
      3'd1: return 4'd2;
      3'd2: return 4'd3;
      3'd3: return 4'd4;
      3'd4: return 4'd5;
      3'd5: return alt ? 4'd7 : 4'd6;
      3'd6: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic br_outcome(logic [2:0] f3, logic eq, logic lt);
    case (f3)
      3'b000: return eq;
      3'b001: return !eq;
      3'b100, 3'b110: return lt;
      3'b101, 3'b111: return !lt;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [13:0] expect_out(logic [31:0] iw, logic eq, logic lt);
    logic [2:0] f3;
    f3 = iw[14:12];
    case (iw[6:0])
      7'b0110011: return pack_out(2'd0, 1, 0, 0, 0, arith_op(f3, iw[30], 1), 0, 2'd1, 0);
      7'b0010011: return pack_out(2'd0, 1, 0, 0, 1, arith_op(f3, iw[30], 0), 0, 2'd1, 0);
      7'b0000011: return pack_out(2'd0, 1, 0, 0, 1, 4'd0, 0, 2'd0, 0);
      7'b0100011: return pack_out(2'd1, 0, 0, 0, 1, 4'd0, 1, 2'd1, 0);
      7'b1100011: return pack_out(2'd2, 0, (f3 == 3'b110 || f3 == 3'b111), 1, 1, 4'd0, 0,
                                  2'd1, br_outcome(f3, eq, lt));
      7'b1100111: return pack_out(2'd0, 1, 0, 0, 1, 4'd0, 0, 2'd2, 1);
      7'b1101111: return pack_out(2'd3, 1, 0, 1, 1, 4'd0, 0, 2'd2, 1);
      default:    return pack_out(2'd0, 0, 0, 0, 0, 4'd0, 0, 2'd1, 0);
    endcase
  endfunction

  function automatic string class_tag(logic [31:0] iw);
    case (iw[6:0])
      7'b0110011: return "R1";
      7'b0010011: return "R2";
      7'b0000011: return "R3";
      7'b0100011: return "R4";
      7'b1100011: return "R6";
      7'b1100111: return "R8";
      7'b1101111: return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic apply_check(logic [31:0] iw, logic eq, logic lt, string tag);
    logic [13:0] got, exp;
    @(negedge clk);
    instr_word = iw;
    cmp_eq     = eq;
    cmp_lt     = lt;
    #1;
    got = pack_out(imm_fmt, rf_wen, cmp_unsigned, opa_pc, opb_imm, alu_op, dmem_wen,
                   wb_src, pc_redirect);
    exp = expect_out(iw, eq, lt);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s instr=%h eq=%0b lt=%0b actual=%b expected=%b", tag, iw, eq, lt,
               got, exp);
    end
  endtask

  task automatic check_bit(logic actual, logic expected, string tag);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  initial begin
    int unsigned seed;
    instr_word = 32'h0;
    cmp_eq     = 1'b0;
    cmp_lt     = 1'b0;
    seed = $urandom(32'h5EED_0151);

    // R10: all-zero word is unrecognised and is the idle state
    apply_check(32'h0000_0000, 0, 0, "R10");
    apply_check(32'h0000_0037, 1, 1, "R10");   // upper-immediate opcode not decoded

    // R1: add, sub, sra, srl, and
    apply_check(32'h0031_00B3, 0, 0, "R1");    // add x1,x2,x3
    apply_check(32'h4031_00B3, 0, 0, "R1");    // sub
    apply_check(32'h4031_50B3, 0, 0, "R1");    // sra
    apply_check(32'h0031_50B3, 0, 0, "R1");    // srl
    apply_check(32'h0031_70B3, 0, 0, "R1");    // and
    // R11: flags set on non-control instruction keep PC+4
    apply_check(32'h0031_00B3, 1, 1, "R11");
    @(negedge clk); #1;
    check_bit(pc_redirect, 1'b0, "R11");

    // R2: addi -50 (bit30 set must not give sub), srai, slti
    apply_check(32'hFCE0_8793, 0, 0, "R2");
    apply_check(32'h4020_D093, 0, 0, "R2");
    apply_check(32'h0050_A093, 0, 0, "R2");

    // R3 / R4
    apply_check(32'h0081_2703, 0, 0, "R3");    // lw x14,8(x2)
    apply_check(32'h00E1_2423, 1, 0, "R4");    // sw x14,8(x2)

    // R5 / R6 / R7: each branch condition both ways
    for (int f = 0; f < 8; f++) begin
      for (int fl = 0; fl < 4; fl++) begin
        logic [31:0] bw;
        bw = {17'h00208, 3'(f), 12'h463};
        apply_check(bw, fl[0], fl[1], (f == 6 || f == 7) ? "R7" : "R6");
      end
    end
    apply_check(32'h0020_8463, 1, 0, "R5");    // beq taken
    check_bit(rf_wen, 1'b0, "R5");
    apply_check(32'h0020_A463, 1, 1, "R6");    // reserved funct3 010 never taken
    check_bit(pc_redirect, 1'b0, "R6");

    // R8 / R9
    apply_check(32'h0000_80E7, 0, 0, "R8");
    apply_check(32'h0080_00EF, 1, 1, "R9");

    // Random: pick opcode from the known set or a random one
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] w;
      logic [6:0]  opcs [7];
      int          pick;
      opcs = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011,
               7'b1100011, 7'b1100111, 7'b1101111};
      w    = $urandom;
      pick = $urandom_range(0, 8);
      if (pick < 7) w[6:0] = opcs[pick];
      apply_check(w, 1'($urandom), 1'($urandom), class_tag(w));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule